// File: doc/BRIEF.md
# DRAM Address-Multiplexing and Refresh Controller

This block connects a simple valid/ready request port to a DRAM array of 2048 rows by 2048 columns with 4-bit data, 16 Mbit in all. A request carries a 22-bit address, a read/write flag and write data. The controller splits the address into a row half and a column half. It sends the two halves one after the other over one shared 11-bit address bus. The row strobe marks the row half and the column strobe marks the column half. Read data comes back on a response channel as a single-cycle valid pulse.

The block also keeps the array alive. A free-running interval counter raises a refresh request at a fixed rate. The controller answers it with a row-only strobe cycle: the row strobe goes low, the column strobe stays high, and the row comes from an internal counter that steps through every row in turn. User requests are held off while a refresh is pending or running. An access that is already in flight always finishes first. Every operation is followed by a fixed recovery gap with both strobes high, so one cycle of the array lasts the access time plus the recovery time.

Top module: `dram_mux_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, both strobes are high (inactive), `rsp_valid` is 0, and the first refresh uses row 0.
- R2: For an access, `dram_addr` carries `req_addr[21:11]` (the row) when the row strobe falls. The row strobe stays low alone for T_RCD cycles. `dram_addr` then carries `req_addr[10:0]` (the column) when the column strobe falls. The column strobe is never low while the row strobe is high.
- R3: For a write, `dram_we_n` is low and `dram_dq_oe` is 1 with the request's data on `dram_dq_out` while the column strobe is low. A later read of the same address returns that data.
- R4: A read samples `dram_dq_in` at the end of its column phase. It then raises `rsp_valid` for exactly one cycle with that value on `rsp_rdata`. A write produces no response.
- R5: A refresh holds the row strobe low for T_RAS cycles with the column strobe high throughout. `dram_addr` carries the refresh row, and each refresh advances the row by one.
- R6: The refresh row wraps from 2047 back to 0.
- R7: While no accesses intervene, refresh cycles start exactly REF_INTERVAL clock cycles apart.
- R8: An access in flight finishes before a pending refresh starts. No new request is accepted while a refresh is pending or running.
- R9: Between any two consecutive operations, the row strobe stays high for at least T_PRE cycles.
- R10: `req_ready` is 1 only when both strobes are high and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Row in [21:11], column in [10:0] |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 4 | Read data |
| dram_addr | output | 11 | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 4 | Data driven to the array |
| dram_dq_oe | output | 1 | Output enable for dram_dq_out |
| dram_dq_in | input | 4 | Data returned by the array |

## Verification
The bench keeps the full 11-bit row and column widths and 4-bit data, so corner addresses such as all-zero, all-one, and maximum row with column zero reach the real bus. It shortens the refresh interval to 40 cycles and uses strobe timings of 2, 2, 2 and 3 cycles. With these values more than 2048 refreshes fit in the run, so the wrap from row 2047 to row 0 is observed, and refresh requests often fall in the middle of user accesses. A behavioural array model in the bench decodes the strobes and serves the data.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_PRE,
    ST_REF
  } seq_state_t;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int ROW_W        = 11,
  parameter int REF_INTERVAL = 780
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_start,
  input  logic             ref_done,
  output logic             ref_pending,
  output logic [ROW_W-1:0] ref_row
);
  localparam int TW   = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam int ROWS = 1 << ROW_W;

  // Next row to refresh, wrapping at the top of the array.
  function automatic logic [ROW_W-1:0] next_row(input logic [ROW_W-1:0] r);
    return (int'(r) == ROWS - 1) ? '0 : r + 1'b1;
  endfunction

  logic [TW-1:0] tick_cnt;
  logic          tick;

  assign tick = (int'(tick_cnt) == REF_INTERVAL - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt    <= '0;
      ref_pending <= 1'b0;
      ref_row     <= '0;
    end else begin
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
      // A new tick wins over the clear caused by a refresh starting.
      if (tick)           ref_pending <= 1'b1;
      else if (ref_start) ref_pending <= 1'b0;
      if (ref_done) ref_row <= next_row(ref_row);
    end
  end
endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
  import dram_mux_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 4,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_PRE  = 2,
  parameter int T_RAS  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   req_ready,
  input  logic                   ref_pending,
  input  logic [ROW_W-1:0]       ref_row,
  output logic                   ref_start,
  output logic                   ref_done,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [ROW_W-1:0]       dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  localparam int M1   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int M2   = (T_PRE > T_RAS) ? T_PRE : T_RAS;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int PW   = $clog2(TMAX + 1);
  localparam int BUSW = (ROW_W > COL_W) ? ROW_W : COL_W;

  // Length of a phase minus one, loaded into the phase counter on entry.
  function automatic logic [PW-1:0] phase_last(input seq_state_t s);
    case (s)
      ST_ROW:  return PW'(T_RCD - 1);
      ST_COL:  return PW'(T_CAS - 1);
      ST_PRE:  return PW'(T_PRE - 1);
      ST_REF:  return PW'(T_RAS - 1);
      default: return '0;
    endcase
  endfunction

  seq_state_t          state;
  logic [PW-1:0]       cnt;
  logic [ROW_W-1:0]    op_row;
  logic [COL_W-1:0]    op_col;
  logic                op_wr;
  logic [DATA_W-1:0]   op_wdata;
  logic                phase_end;
  logic [BUSW-1:0]     bus_mux;

  assign phase_end = (cnt == '0);
  assign ref_start = (state == ST_IDLE) && ref_pending;
  assign ref_done  = (state == ST_REF) && phase_end;
  assign req_ready = (state == ST_IDLE) && !ref_pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      op_row    <= '0;
      op_col    <= '0;
      op_wr     <= 1'b0;
      op_wdata  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ref_pending) begin
            state <= ST_REF;
            cnt   <= phase_last(ST_REF);
          end else if (req_valid) begin
            op_row   <= req_addr[ROW_W+COL_W-1:COL_W];
            op_col   <= req_addr[COL_W-1:0];
            op_wr    <= req_write;
            op_wdata <= req_wdata;
            state    <= ST_ROW;
            cnt      <= phase_last(ST_ROW);
          end
        end
        ST_ROW: begin
          if (phase_end) begin
            state <= ST_COL;
            cnt   <= phase_last(ST_COL);
          end else cnt <= cnt - 1'b1;
        end
        ST_COL: begin
          if (phase_end) begin
            if (!op_wr) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= dram_dq_in;
            end
            state <= ST_PRE;
            cnt   <= phase_last(ST_PRE);
          end else cnt <= cnt - 1'b1;
        end
        ST_REF: begin
          if (phase_end) begin
            state <= ST_PRE;
            cnt   <= phase_last(ST_PRE);
          end else cnt <= cnt - 1'b1;
        end
        ST_PRE: begin
          if (phase_end) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_mux = '0;
    case (state)
      ST_ROW:  bus_mux = BUSW'(op_row);
      ST_COL:  bus_mux = BUSW'(op_col);
      ST_REF:  bus_mux = BUSW'(ref_row);
      default: bus_mux = '0;
    endcase
  end

  assign dram_addr   = bus_mux[ROW_W-1:0];
  assign dram_ras_n  = !((state == ST_ROW) || (state == ST_COL) || (state == ST_REF));
  assign dram_cas_n  = !(state == ST_COL);
  assign dram_dq_oe  = (state == ST_COL) && op_wr;
  assign dram_we_n   = !dram_dq_oe;
  assign dram_dq_out = op_wdata;
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 11,
  parameter int DATA_W       = 4,
  parameter int REF_INTERVAL = 780,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_PRE        = 2,
  parameter int T_RAS        = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [ROW_W-1:0]       dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  // Internal events, named for the checker.
  logic             ref_start;
  logic             ref_done;
  logic             ref_pending;
  logic [ROW_W-1:0] ref_row;

  dram_refresh_timer #(
    .ROW_W(ROW_W),
    .REF_INTERVAL(REF_INTERVAL)
  ) u_timer (
    .clk(clk),
    .rst_n(rst_n),
    .ref_start(ref_start),
    .ref_done(ref_done),
    .ref_pending(ref_pending),
    .ref_row(ref_row)
  );

  dram_strobe_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_PRE(T_PRE), .T_RAS(T_RAS)
  ) u_seq (
    .clk(clk),
    .rst_n(rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr(req_addr),
    .req_wdata(req_wdata),
    .req_ready(req_ready),
    .ref_pending(ref_pending),
    .ref_row(ref_row),
    .ref_start(ref_start),
    .ref_done(ref_done),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );
endmodule

// File: rtl/dram_mux_checker.sv
module dram_mux_checker #(
  parameter int ROW_W = 11,
  parameter int T_PRE = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             dram_ras_n,
  input logic             dram_cas_n,
  input logic             dram_we_n,
  input logic             ref_start,
  input logic             ref_done,
  input logic [ROW_W-1:0] ref_row
);
  localparam logic [ROW_W-1:0] ROW_TOP = '1;
  localparam int HW = 8;

  // Consecutive cycles with the row strobe high, saturating.
  logic [HW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= '1;
    else if (!dram_ras_n) hi_cnt <= '0;
    else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
  end

  a_r2_col_inside_row: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);
  a_r3_write_in_col: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> !dram_cas_n);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r5_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_done && ref_row != ROW_TOP) |=> ref_row == $past(ref_row) + 1'b1);
  a_r6_row_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_done && ref_row == ROW_TOP) |=> ref_row == '0);
  a_r8_refresh_from_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    ref_start |-> (dram_ras_n && dram_cas_n && !req_ready));
  a_r9_recovery_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> hi_cnt >= HW'(T_PRE));
  a_r10_ready_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dram_ras_n && dram_cas_n));
endmodule

bind dram_mux_ctrl dram_mux_checker #(.ROW_W(ROW_W), .T_PRE(T_PRE)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .dram_ras_n(dram_ras_n),
  .dram_cas_n(dram_cas_n),
  .dram_we_n(dram_we_n),
  .ref_start(ref_start),
  .ref_done(ref_done),
  .ref_row(ref_row)
);

// File: tb/sim_dram_mux_ctrl.sv
`timescale 1ns/1ps
module sim_dram_mux_ctrl;
  localparam int ROW_W = 11, COL_W = 11, DATA_W = 4;
  localparam int REF_INTERVAL = 40;
  localparam int T_RCD = 2, T_CAS = 2, T_PRE = 2, T_RAS = 3;
  localparam int ROWS = 1 << ROW_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [21:0] req_addr = '0;
  logic [3:0] req_wdata = '0;
  logic rsp_valid;
  logic [3:0] rsp_rdata;
  logic [10:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [3:0] dram_dq_out;
  logic [3:0] dram_dq_in = '0;

  always #5 clk = ~clk;

  dram_mux_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .REF_INTERVAL(REF_INTERVAL),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_PRE(T_PRE), .T_RAS(T_RAS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Content of a never-written location in the array model.
  function automatic logic [3:0] fill_pat(input logic [21:0] a);
    return a[3:0] ^ a[14:11] ^ 4'hA;
  endfunction

  // Scoreboard state
  logic [21:0] addr_q[$];
  logic [3:0]  rd_q[$];
  logic [3:0]  shadow [int];
  logic [3:0]  array_m [int];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic do_req(input bit wr, input logic [21:0] a, input logic [3:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    addr_q.push_back(a);
    if (wr) shadow[int'(a)] = d;
    else rd_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : fill_pat(a));
    @(negedge clk);
    req_valid = 0;
  endtask

  // Array model and monitors, all sampled at the falling edge.
  bit prev_ras_n = 1, prev_cas_n = 1, prev_rsp = 0, period_cas = 0;
  logic [10:0] cur_row = '0;
  int ras_low_cnt = 0, fall_cyc = 0, rise_cyc = -100;
  int last_access_rise = -100, prev_ref_fall = -100000;
  bit prev_ref_clean = 0;
  int exp_ref_row = 0, ref_count = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      // R10 / R8: ready only with an idle bus
      if (req_ready && (!dram_ras_n || !dram_cas_n))
        chk(0, "R10", "ready with strobe active", 1, 0);
      if (!dram_ras_n) chk(!req_ready, "R8", "ready during operation", int'(req_ready), 0);
      if (!dram_ras_n && prev_ras_n) begin
        chk(cyc - rise_cyc >= T_PRE, "R9", "recovery cycles", cyc - rise_cyc, T_PRE);
        cur_row = dram_addr; period_cas = 0; ras_low_cnt = 0; fall_cyc = cyc;
      end
      if (!dram_ras_n && dram_cas_n && !period_cas) ras_low_cnt++;
      if (!dram_cas_n && prev_cas_n) begin
        logic [21:0] ea;
        int key;
        period_cas = 1;
        key = int'({cur_row, dram_addr});
        if (addr_q.size() == 0) chk(0, "R2", "unexpected column strobe", 1, 0);
        else begin
          ea = addr_q.pop_front();
          chk(cur_row == ea[21:11], "R2", "row half", int'(cur_row), int'(ea[21:11]));
          chk(dram_addr == ea[10:0], "R2", "column half", int'(dram_addr), int'(ea[10:0]));
          chk(ras_low_cnt == T_RCD, "R2", "row-to-column cycles", ras_low_cnt, T_RCD);
        end
        if (!dram_we_n) begin
          chk(dram_dq_oe, "R3", "output enable on write", int'(dram_dq_oe), 1);
          array_m[key] = dram_dq_out;
        end
      end
      if (!dram_cas_n && dram_we_n) begin
        int key;
        key = int'({cur_row, dram_addr});
        dram_dq_in = array_m.exists(key) ? array_m[key] : fill_pat(key[21:0]);
      end
      if (dram_ras_n && !prev_ras_n) begin
        rise_cyc = cyc;
        if (!period_cas) begin
          bit clean;
          if (ref_count > 0 && exp_ref_row == 0)
            chk(cur_row == 0, "R6", "refresh row after wrap", int'(cur_row), 0);
          else
            chk(int'(cur_row) == exp_ref_row, "R5", "refresh row", int'(cur_row), exp_ref_row);
          chk(cyc - fall_cyc == T_RAS, "R5", "refresh strobe length", cyc - fall_cyc, T_RAS);
          clean = fall_cyc > last_access_rise + T_PRE + 1;
          if (prev_ref_clean && last_access_rise < prev_ref_fall)
            chk(fall_cyc - prev_ref_fall == REF_INTERVAL, "R7", "refresh spacing",
                fall_cyc - prev_ref_fall, REF_INTERVAL);
          prev_ref_clean = clean;
          prev_ref_fall = fall_cyc;
          exp_ref_row = (exp_ref_row + 1) % ROWS;
          ref_count++;
        end else last_access_rise = cyc;
      end
      // R4 response monitor
      if (rsp_valid) begin
        chk(!prev_rsp, "R4", "response pulse width", 2, 1);
        if (rd_q.size() == 0) chk(0, "R4", "response without read", 1, 0);
        else begin
          logic [3:0] e;
          e = rd_q.pop_front();
          chk(rsp_rdata == e, "R3", "read data", int'(rsp_rdata), int'(e));
        end
      end
      prev_rsp = rsp_valid;
      prev_ras_n = dram_ras_n;
      prev_cas_n = dram_cas_n;
    end
  end

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready, "R1", "ready after reset", int'(req_ready), 1);
    chk(dram_ras_n && dram_cas_n, "R1", "strobes after reset",
        int'({dram_ras_n, dram_cas_n}), 3);
    chk(!rsp_valid, "R1", "no response after reset", int'(rsp_valid), 0);
    // Corner writes
    do_req(1, 22'h000000, 4'h3);
    do_req(1, 22'h3FFFFF, 4'hC);
    do_req(1, 22'h3FF800, 4'h9);
    do_req(1, 22'h0007FF, 4'h6);
    do_req(1, 22'h12A5C3, 4'hE);
    // Read back, plus an untouched location
    do_req(0, 22'h000000, 4'h0);
    do_req(0, 22'h3FFFFF, 4'h0);
    do_req(0, 22'h3FF800, 4'h0);
    do_req(0, 22'h0007FF, 4'h0);
    do_req(0, 22'h12A5C3, 4'h0);
    do_req(0, 22'h2B1D04, 4'h0);
    // Mixed traffic over a small address pool, crossing refresh ticks
    lf = 32'h1ACE5EED;
    for (int i = 0; i < 120; i++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      do_req(lf[0], {lf[20:18], 8'h00, lf[10:9], 9'h0F0}, lf[27:24]);
    end
    // Let the refresh row run through the whole array and wrap
    while (ref_count < ROWS + 4) @(negedge clk);
    do_req(0, 22'h3FFFFF, 4'h0);
    do_req(1, 22'h155555, 4'h5);
    do_req(0, 22'h155555, 4'h0);
    repeat (40) @(negedge clk);
    chk(rd_q.size() == 0, "R4", "reads left unanswered", rd_q.size(), 0);
    chk(addr_q.size() == 0, "R2", "accesses never issued", addr_q.size(), 0);
    chk(ref_count >= ROWS + 1, "R6", "refreshes seen", ref_count, ROWS + 1);
    finish_run();
  end
endmodule